// File: doc/BRIEF.md
# Operand Effective-Address Resolver

This block turns the operand field of an instruction into the value the instruction works on, or into the address it targets. The surrounding control unit presents an operand, a 3-bit mode code, the current program counter and an index register, then pulses `start`. The resolver reads from a memory with one cycle of read latency as many times as the mode needs. It then raises `done` for one cycle and presents the effective address and the operand value. Decoding the opcode, running the ALU and writing results back belong to the control unit.

The five modes are as follows. Immediate takes the operand as the value. Direct reads the location the operand names. Indirect reads a pointer from the named location and then reads the location it points to. Indexed reads at operand plus index. Relative adds the operand, taken as a signed offset, to the program counter to form a branch target. The three spare mode codes are reported as illegal. Address arithmetic wraps within the address space.

Top module: `operand_resolver`

## Requirements
- R1: During and right after reset, `done`, `illegal`, `mem_rd_en`, `eff_addr` and `data_out` are all 0.
- R2: Mode 3'b000 (immediate): `done` rises in the first cycle after the start edge, with `eff_addr` = operand and `data_out` = operand, and no memory read is made.
- R3: Mode 3'b001 (direct): one read at address operand; `done` rises two cycles after the start edge with `eff_addr` = operand and `data_out` = memory[operand].
- R4: Mode 3'b010 (indirect): a read at the operand returns a pointer, then a second read at that pointer; `done` rises three cycles after the start edge with `eff_addr` = pointer and `data_out` = memory[pointer].
- R5: Mode 3'b011 (indexed): one read at (operand + index) mod 2^AW; `done` rises two cycles after the start edge with that address on `eff_addr` and its contents on `data_out`.
- R6: Mode 3'b100 (relative): `eff_addr` = (pc + operand) mod 2^AW, the operand read as two's complement, and `data_out` equals that target. `done` rises one cycle after the start edge and no memory read is made.
- R7: Mode codes 3'b101, 3'b110 and 3'b111 complete one cycle after the start edge with no memory read, `illegal` = 1, `eff_addr` = 0 and `data_out` = 0. The next legal completion clears `illegal`.
- R8: `done` is high for exactly one cycle per accepted request.
- R9: A `start` that arrives from the accepting edge through the `done` cycle is ignored. It causes no extra read and no extra completion, and it does not alter the result.
- R10: `eff_addr`, `data_out` and `illegal` change only on the edge that raises `done`, and they hold their values between completions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Request to resolve the presented operand |
| mode | input | 3 | Addressing mode code |
| operand | input | AW | Operand field of the instruction |
| pc | input | AW | Current program counter |
| idx | input | AW | Index register value |
| mem_rd_en | output | 1 | Memory read strobe |
| mem_addr | output | AW | Memory read address |
| mem_rdata | input | DW | Read data, valid one cycle after the strobe |
| done | output | 1 | One-cycle completion pulse |
| illegal | output | 1 | Last completed request used an undefined mode |
| eff_addr | output | AW | Resolved effective address or branch target |
| data_out | output | DW | Resolved operand value |

## Verification
The bench builds the resolver with its default widths of 8 address bits and 8 data bits. With these widths a 256-entry memory model covers the full address space. The indexed sum and the relative target can then be pushed past the top and bottom of the space to show wrap-around, and every one of the eight mode codes, the three illegal ones included, can be applied directly.

// File: rtl/ar_pkg.sv
`timescale 1ns/1ps
// Shared definitions for the operand resolver: mode codes, sequencer
// states and small helpers used by both the sequencer and the top.
package ar_pkg;

    localparam logic [2:0] MODE_IMM = 3'b000;
    localparam logic [2:0] MODE_DIR = 3'b001;
    localparam logic [2:0] MODE_IND = 3'b010;
    localparam logic [2:0] MODE_IDX = 3'b011;
    localparam logic [2:0] MODE_REL = 3'b100;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RD1  = 2'd1,
        ST_RD2  = 2'd2,
        ST_FIN  = 2'd3
    } seq_state_t;

    // True for the modes that must touch memory at least once.
    function automatic logic mode_reads(input logic [2:0] m);
        return (m == MODE_DIR) || (m == MODE_IND) || (m == MODE_IDX);
    endfunction

    // True for the five defined mode codes.
    function automatic logic mode_legal(input logic [2:0] m);
        return m <= MODE_REL;
    endfunction

endpackage

// File: rtl/ar_addr_calc.sv
`timescale 1ns/1ps
// Address arithmetic for the resolver.
// Produces the first read address (operand, or operand plus index in
// indexed mode) and the relative branch target. Both sums are taken at
// AW bits so they wrap modulo 2^AW; for the relative target a plain
// AW-bit add of a two's-complement offset already gives the signed result.
// Assumes: purely combinational, inputs stable during the start cycle.
module ar_addr_calc
    import ar_pkg::*;
#(
    parameter int AW = 8
) (
    input  logic [2:0]    mode_i,
    input  logic [AW-1:0] operand_i,
    input  logic [AW-1:0] pc_i,
    input  logic [AW-1:0] idx_i,
    output logic [AW-1:0] first_addr_o,
    output logic [AW-1:0] rel_target_o
);

    logic [AW-1:0] indexed_sum;

    // Wrapping sums for indexed and relative addressing.
    always_comb begin
        indexed_sum  = operand_i + idx_i;
        rel_target_o = pc_i + operand_i;
    end

    // First memory address depends on whether the index is applied.
    always_comb begin
        first_addr_o = (mode_i == MODE_IDX) ? indexed_sum : operand_i;
    end

endmodule

// File: rtl/ar_seq.sv
`timescale 1ns/1ps
// Resolution sequencer.
// Accepts a request only when idle, issues the first read in the start
// cycle itself, a second read (indirect only) in the cycle the pointer
// returns, and spends one cycle in FIN where done is high.
// Assumes: memory returns data exactly one cycle after the read strobe.
module ar_seq
    import ar_pkg::*;
#(
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic [2:0]    mode_i,
    input  logic [AW-1:0] first_addr_i,
    input  logic [AW-1:0] ptr_i,
    output logic          busy_o,
    output logic          rd_en_o,
    output logic          sel_ptr_o,
    output logic          ld_now_o,
    output logic          ld_mem_o,
    output logic          done_o,
    output logic [AW-1:0] work_addr_o
);

    seq_state_t    st, st_nx;
    logic [2:0]    mode_q;
    logic          accept;
    logic          is_ind_q;

    // Request acceptance and per-state control decode.
    always_comb begin
        accept    = start_i && (st == ST_IDLE);
        is_ind_q  = (mode_q == MODE_IND);
        busy_o    = (st != ST_IDLE);
        rd_en_o   = (accept && mode_reads(mode_i)) || ((st == ST_RD1) && is_ind_q);
        sel_ptr_o = (st == ST_RD1);
        ld_now_o  = accept && !mode_reads(mode_i);
        ld_mem_o  = ((st == ST_RD1) && !is_ind_q) || (st == ST_RD2);
        done_o    = (st == ST_FIN);
    end

    // Next-state selection.
    always_comb begin
        st_nx = st;
        unique case (st)
            ST_IDLE: if (accept) st_nx = mode_reads(mode_i) ? ST_RD1 : ST_FIN;
            ST_RD1:  st_nx = is_ind_q ? ST_RD2 : ST_FIN;
            ST_RD2:  st_nx = ST_FIN;
            ST_FIN:  st_nx = ST_IDLE;
            default: st_nx = ST_IDLE;
        endcase
    end

    // State, latched mode and working address registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st          <= ST_IDLE;
            mode_q      <= MODE_IMM;
            work_addr_o <= '0;
        end else begin
            st <= st_nx;
            if (accept) begin
                mode_q      <= mode_i;
                work_addr_o <= first_addr_i;
            end else if ((st == ST_RD1) && is_ind_q) begin
                work_addr_o <= ptr_i;
            end
        end
    end

endmodule

// File: rtl/ar_result.sv
`timescale 1ns/1ps
// Result holding registers.
// Loads address, value and illegal flag together on a single load strobe
// and otherwise holds them, so outputs change only at completion.
// Assumes: load strobe is high for at most one cycle per request.
module ar_result #(
    parameter int AW = 8,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ld_i,
    input  logic [AW-1:0] ea_i,
    input  logic [DW-1:0] data_i,
    input  logic          ill_i,
    output logic [AW-1:0] ea_o,
    output logic [DW-1:0] data_o,
    output logic          ill_o
);

    // Capture the resolved outcome when loaded.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ea_o   <= '0;
            data_o <= '0;
            ill_o  <= 1'b0;
        end else if (ld_i) begin
            ea_o   <= ea_i;
            data_o <= data_i;
            ill_o  <= ill_i;
        end
    end

endmodule

// File: rtl/operand_resolver.sv
`timescale 1ns/1ps
// Operand effective-address resolver (top).
// Resolves an operand in one of five addressing modes using zero, one or
// two reads of a memory with one cycle of read latency, and reports the
// result with a one-cycle done pulse.
// Assumes: DW >= AW so a read word can carry a pointer; the memory read
// address is combinational from start/mode/operand in the start cycle.
module operand_resolver
    import ar_pkg::*;
#(
    parameter int AW = 8,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [2:0]    mode,
    input  logic [AW-1:0] operand,
    input  logic [AW-1:0] pc,
    input  logic [AW-1:0] idx,
    output logic          mem_rd_en,
    output logic [AW-1:0] mem_addr,
    input  logic [DW-1:0] mem_rdata,
    output logic          done,
    output logic          illegal,
    output logic [AW-1:0] eff_addr,
    output logic [DW-1:0] data_out
);

    logic [AW-1:0] first_addr;
    logic [AW-1:0] rel_target;
    logic [AW-1:0] ptr;
    logic [AW-1:0] work_addr;
    logic          busy;
    logic          sel_ptr;
    logic          ld_now;
    logic          ld_mem;
    logic          ld;
    logic [AW-1:0] ea_nx;
    logic [DW-1:0] data_nx;
    logic          ill_nx;

    ar_addr_calc #(.AW(AW)) u_calc (
        .mode_i       (mode),
        .operand_i    (operand),
        .pc_i         (pc),
        .idx_i        (idx),
        .first_addr_o (first_addr),
        .rel_target_o (rel_target)
    );

    ar_seq #(.AW(AW)) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start),
        .mode_i       (mode),
        .first_addr_i (first_addr),
        .ptr_i        (ptr),
        .busy_o       (busy),
        .rd_en_o      (mem_rd_en),
        .sel_ptr_o    (sel_ptr),
        .ld_now_o     (ld_now),
        .ld_mem_o     (ld_mem),
        .done_o       (done),
        .work_addr_o  (work_addr)
    );

    // Pointer bits of the read word and the memory address mux.
    always_comb begin
        ptr      = mem_rdata[AW-1:0];
        mem_addr = sel_ptr ? ptr : first_addr;
    end

    // Outcome to be loaded: immediate forms at accept, memory forms on return.
    always_comb begin
        ld      = ld_now || ld_mem;
        ea_nx   = work_addr;
        data_nx = mem_rdata;
        ill_nx  = 1'b0;
        if (ld_now) begin
            if (mode == MODE_IMM) begin
                ea_nx   = operand;
                data_nx = DW'(operand);
            end else if (mode == MODE_REL) begin
                ea_nx   = rel_target;
                data_nx = DW'(rel_target);
            end else begin
                ea_nx   = '0;
                data_nx = '0;
                ill_nx  = !mode_legal(mode);
            end
        end
    end

    ar_result #(.AW(AW), .DW(DW)) u_res (
        .clk    (clk),
        .rst_n  (rst_n),
        .ld_i   (ld),
        .ea_i   (ea_nx),
        .data_i (data_nx),
        .ill_i  (ill_nx),
        .ea_o   (eff_addr),
        .data_o (data_out),
        .ill_o  (illegal)
    );

endmodule

// File: rtl/ar_checker.sv
`timescale 1ns/1ps
// Property checker for operand_resolver, attached by bind.
module ar_checker #(
    parameter int AW = 8,
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic [2:0]    mode,
    input logic          busy,
    input logic          mem_rd_en,
    input logic          done,
    input logic          illegal,
    input logic [AW-1:0] eff_addr,
    input logic [DW-1:0] data_out
);

    logic acc;
    assign acc = start && !busy;

    a_r8_done_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r2_imm_next_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && mode == 3'b000) |=> done);

    a_r2_imm_no_read: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && mode == 3'b000) |-> !mem_rd_en);

    a_r6_rel_no_read: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && mode == 3'b100) |-> !mem_rd_en);

    a_r7_bad_no_read: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && mode > 3'b100) |-> !mem_rd_en);

    a_r7_bad_zeroed: assert property (@(posedge clk) disable iff (!rst_n)
        (done && illegal) |-> (eff_addr == '0 && data_out == '0));

    a_r3_direct_two: assert property (@(posedge clk) disable iff (!rst_n)
        $past(acc && mode == 3'b001, 2) |-> done);

    a_r4_indirect_three: assert property (@(posedge clk) disable iff (!rst_n)
        $past(acc && mode == 3'b010, 3) |-> done);

    a_r10_hold_between: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> ($stable(eff_addr) && $stable(data_out) && $stable(illegal)));

    a_r9_no_read_in_fin: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !mem_rd_en);

endmodule

bind operand_resolver ar_checker #(.AW(AW), .DW(DW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .mode      (mode),
    .busy      (busy),
    .mem_rd_en (mem_rd_en),
    .done      (done),
    .illegal   (illegal),
    .eff_addr  (eff_addr),
    .data_out  (data_out)
);

// File: tb/sim_operand_resolver.sv
`timescale 1ns/1ps
// Directed bench for operand_resolver with a one-cycle-latency memory model.
module sim_operand_resolver;

    localparam int AW = 8;
    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [2:0]    mode = 3'b000;
    logic [AW-1:0] operand = '0;
    logic [AW-1:0] pc = '0;
    logic [AW-1:0] idx = '0;
    logic          mem_rd_en;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_rdata = '0;
    logic          done;
    logic          illegal;
    logic [AW-1:0] eff_addr;
    logic [DW-1:0] data_out;

    logic [DW-1:0] mem [256];
    int n_chk = 0;
    int n_bad = 0;
    int rd_count = 0;

    always #5 clk = ~clk;

    operand_resolver #(.AW(AW), .DW(DW)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .mode(mode),
        .operand(operand), .pc(pc), .idx(idx),
        .mem_rd_en(mem_rd_en), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
        .done(done), .illegal(illegal), .eff_addr(eff_addr), .data_out(data_out)
    );

    // Memory model: one cycle of read latency; counts reads.
    always @(posedge clk) begin
        if (mem_rd_en) begin
            mem_rdata <= mem[mem_addr];
            rd_count  <= rd_count + 1;
        end
    end

    task automatic chk(input string rq, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
        end
    endtask

    // Apply one request and check latency, reads, results and pulse width.
    task automatic run_case(input string rq, input logic [2:0] m, input logic [7:0] op,
                            input logic [7:0] pcv, input logic [7:0] xv,
                            input int e_ea, input int e_dat, input int e_ill,
                            input int e_lat, input int e_rd);
        int lat;
        int rd0;
        @(negedge clk);
        rd0 = rd_count;
        start = 1'b1; mode = m; operand = op; pc = pcv; idx = xv;
        @(negedge clk);
        start = 1'b0;
        lat = 1;
        while (!done && lat < 8) begin
            @(negedge clk);
            lat++;
        end
        chk(rq, "latency", lat, e_lat);
        chk(rq, "eff_addr", int'(eff_addr), e_ea);
        chk(rq, "data_out", int'(data_out), e_dat);
        chk(rq, "illegal", int'(illegal), e_ill);
        chk(rq, "reads", rd_count - rd0, e_rd);
        @(negedge clk);
        chk("R8", "done width", int'(done), 0);
    endtask

    task automatic t_reset();
        chk("R1", "done", int'(done), 0);
        chk("R1", "illegal", int'(illegal), 0);
        chk("R1", "mem_rd_en", int'(mem_rd_en), 0);
        chk("R1", "eff_addr", int'(eff_addr), 0);
        chk("R1", "data_out", int'(data_out), 0);
    endtask

    task automatic t_immediate();
        run_case("R2", 3'b000, 8'd5, 8'd0, 8'd0, 5, 5, 0, 1, 0);
        run_case("R2", 3'b000, 8'hFF, 8'd9, 8'd3, 255, 255, 0, 1, 0);
    endtask

    task automatic t_direct();
        mem[12] = 8'd7;
        run_case("R3", 3'b001, 8'd12, 8'd0, 8'd0, 12, 7, 0, 2, 1);
        run_case("R3", 3'b001, 8'd200, 8'd0, 8'd0, 200, int'(mem[200]), 0, 2, 1);
    endtask

    task automatic t_indirect();
        mem[12] = 8'd27;
        mem[27] = 8'd4;
        run_case("R4", 3'b010, 8'd12, 8'd0, 8'd0, 27, 4, 0, 3, 2);
    endtask

    task automatic t_indexed();
        mem[14] = 8'd6;
        run_case("R5", 3'b011, 8'd12, 8'd0, 8'd2, 14, 6, 0, 2, 1);
        run_case("R5", 3'b011, 8'hFE, 8'd0, 8'd5, 3, int'(mem[3]), 0, 2, 1);
    endtask

    task automatic t_relative();
        run_case("R6", 3'b100, 8'd3, 8'd25, 8'd0, 28, 28, 0, 1, 0);
        run_case("R6", 3'b100, 8'hFD, 8'd25, 8'd0, 22, 22, 0, 1, 0);
        run_case("R6", 3'b100, 8'd5, 8'hFE, 8'd0, 3, 3, 0, 1, 0);
        run_case("R6", 3'b100, 8'hF0, 8'd2, 8'd0, 242, 242, 0, 1, 0);
    endtask

    task automatic t_illegal();
        for (int c = 5; c < 8; c++) begin
            run_case("R7", 3'(c), 8'd12, 8'd25, 8'd2, 0, 0, 1, 1, 0);
        end
        run_case("R7", 3'b000, 8'd9, 8'd0, 8'd0, 9, 9, 0, 1, 0);
    endtask

    // Start pulses during an indirect resolution must not be taken.
    task automatic t_busy_ignore();
        int rd0;
        int lat;
        int extra;
        mem[40] = 8'd90;
        mem[90] = 8'd33;
        @(negedge clk);
        rd0 = rd_count;
        start = 1'b1; mode = 3'b010; operand = 8'd40;
        @(negedge clk);
        mode = 3'b000; operand = 8'h55;
        @(negedge clk);
        start = 1'b0;
        lat = 2;
        while (!done && lat < 8) begin
            @(negedge clk);
            lat++;
        end
        chk("R9", "latency", lat, 3);
        chk("R9", "eff_addr", int'(eff_addr), 90);
        chk("R9", "data_out", int'(data_out), 33);
        extra = 0;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            if (done) extra++;
        end
        chk("R9", "extra completions", extra, 0);
        chk("R9", "reads", rd_count - rd0, 2);
        chk("R9", "data_out after", int'(data_out), 33);
    endtask

    // Inputs moving without start must leave the outputs alone.
    task automatic t_hold();
        run_case("R10", 3'b001, 8'd40, 8'd0, 8'd0, 40, 90, 0, 2, 1);
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            mode = 3'(i); operand = 8'(i * 37); pc = 8'(i * 11); idx = 8'(i);
        end
        chk("R10", "eff_addr held", int'(eff_addr), 40);
        chk("R10", "data_out held", int'(data_out), 90);
        chk("R10", "illegal held", int'(illegal), 0);
        chk("R10", "no done", int'(done), 0);
    endtask

    initial begin
        for (int a = 0; a < 256; a++) mem[a] = 8'(a) ^ 8'hA5;
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_immediate();
        t_direct();
        t_indirect();
        t_indexed();
        t_relative();
        t_illegal();
        t_busy_ignore();
        t_hold();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #2000000;
        n_chk++;
        n_bad++;
        $display("FAIL all watchdog: actual 1 expected 0");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule